// File: doc/BRIEF.md
# SPI Serial Flash Slave Engine

This block answers on an SPI bus the way a small serial NOR flash does. A host selects it with an active-low chip select. The host then clocks in an 8-bit opcode and, for memory commands, a 24-bit address. The block keeps a compact byte array in flops that stands in for the flash cells. The array index is the low `AW` bits of the address.

The block handles four commands:
- **Continuous read:** the block streams bytes out MSB first, with no length limit, until chip select is released. The read pointer wraps from the top of the array back to zero.
- **Byte program:** the block takes one data byte and commits it only when chip select rises. The commit requires an earlier write enable and an address outside the locked region.
- **Write enable:** the block sets a write-enable latch.
- **Status read:** the block reports a Busy bit and the write-enable latch.

A committed program can only clear bits. It starts a self-timed busy interval, during which every command except the status read is dropped.

The SPI pins are oversampled by the system clock. Both idle clock levels (SPI modes 0 and 3) work without configuration. The serial output comes as a data bit plus an output enable, and the pad combines them into a tri-state driver. There is no streaming or handshake interface at the block edge. All traffic passes over the SPI pins.

Top module: `spi_flash_slave`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x00, and every array byte reads 0xFF.
- R2: Opcode 0x03 followed by 24 address bits (MSB first) returns the byte at the address's low `AW` bits, MSB first. Later bytes come from successively higher addresses until chip select rises. Address bits above `AW-1` are ignored.
- R3: After the byte at the top array address (2^AW-1) has been read, the next streamed byte comes from address 0.
- R4: `spi_so_oe` is low during opcode and address bits, and low whenever chip select is high. It is high while read or status data is shifted out.
- R5: A host that idles SCK high (mode 3) gets the same results as one that idles it low (mode 0). In both modes data is sampled on rising SCK and driven after falling SCK.
- R6: Opcode 0x06, completed and followed by chip select rising, sets the write-enable latch. The latch is status bit 1.
- R7: Opcode 0x02 with a 24-bit address and one data byte (MSB first) commits at chip select rise. The stored byte becomes old AND new, so bits only go from 1 to 0.
- R8: A program issued while the write-enable latch is clear leaves the array, the Busy bit and the latch unchanged.
- R9: While `lock_upper` is high, a program to an address whose index MSB (bit `AW-1`) is 1 is ignored. In that case the write-enable latch stays set.
- R10: A committed program sets Busy (status bit 0) for `PROG_CYCLES` clocks. When Busy clears, the write-enable latch clears too.
- R11: A program whose chip select rises before all 8 data bits have arrived is discarded, and the latch is kept.
- R12: While Busy is set, every opcode other than 0x05 is ignored. A read issued then never enables the output, and a program issued then writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sck | input | 1 | SPI serial clock, idle low or high |
| spi_si | input | 1 | Serial data from the host |
| lock_upper | input | 1 | When high, programs to the upper half of the array are refused |
| spi_so | output | 1 | Serial data bit to the host |
| spi_so_oe | output | 1 | Output enable for the serial data pad driver |

## Verification
The assertions assume that every SCK edge and every chip-select change is held for several system clocks. This lets each edge pass through the synchronizer as a distinct single-cycle pulse. They also assume that a chip-select change never reaches the synchronizer in the same cycle as an SCK edge. The stimulus keeps within this by holding each SCK half-period for eight system clocks, and by leaving a half-period gap on both sides of every chip-select transition. It changes SI only while SCK is low. It changes the idle SCK level only while chip select is high.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;

  localparam int OPC_BITS  = 8;
  localparam int ADDR_BITS = 24;
  localparam int DATA_BITS = 8;
  localparam int CNT_W     = $clog2(OPC_BITS + ADDR_BITS + DATA_BITS + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_STREAM,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RESET_VAL}};
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign level = pipe[STAGES-1];
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[i] <= 8'hFF;
      else if (wr_en && wr_addr == AW'(i))
        cells[i] <= cells[i] & wr_data;
    end

    // R7: a program may clear bits but never set one
    p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(i)) |=> ((cells[i] & ~$past(cells[i])) == 8'h00));
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int AW          = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wren_req,
  input  logic          prog_req,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          lock_upper,
  output logic          busy,
  output logic          wel,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] busy_cnt;
  logic          locked;

  assign locked  = lock_upper && prog_addr[AW-1];
  assign busy    = (busy_cnt != '0);
  assign wr_en   = prog_req && wel && !busy && !locked;
  assign wr_addr = prog_addr;
  assign wr_data = prog_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (wr_en) begin
      busy_cnt <= CW'(PROG_CYCLES);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wel <= 1'b0;
    else if (busy && busy_cnt == CW'(1)) wel <= 1'b0;
    else if (wren_req && !busy)       wel <= 1'b1;
  end

  // R10: a commit raises Busy on the next cycle
  p_busy_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  // R10: the busy interval counts down one step per clock
  p_busy_countdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> (busy_cnt == $past(busy_cnt) - 1'b1));

  // R10: write-enable latch is gone once Busy ends
  p_wel_drops_with_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_bit,
  input  logic          busy,
  input  logic          wel,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_addr,
  output logic          so_bit,
  output logic          so_oe,
  output logic          wren_req,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data
);
  localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(OPC_BITS + ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(OPC_BITS + ADDR_BITS + DATA_BITS - 1);

  phase_t             phase;
  logic [CNT_W-1:0]   bitcnt;
  logic [6:0]         in_sr;
  logic [AW-1:0]      addr_q;
  logic [7:0]         opcode;
  logic               data_done;
  logic               src_status;
  logic [7:0]         out_sr;
  logic [2:0]         out_cnt;
  logic               out_live;
  logic [AW-1:0]      ptr;
  logic [7:0]         in_byte;
  logic [AW-1:0]      addr_next;
  logic               shifting_in;

  assign in_byte     = {in_sr, si_bit};
  assign addr_next   = {addr_q[AW-2:0], si_bit};
  assign shifting_in = (phase == PH_OPC) || (phase == PH_ADDR) || (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bitcnt     <= '0;
      in_sr      <= '0;
      addr_q     <= '0;
      opcode     <= '0;
      data_done  <= 1'b0;
      src_status <= 1'b0;
      out_sr     <= '0;
      out_cnt    <= '0;
      out_live   <= 1'b0;
      ptr        <= '0;
      prog_data  <= '0;
    end else if (cs_fall) begin
      phase     <= PH_OPC;
      bitcnt    <= '0;
      opcode    <= '0;
      data_done <= 1'b0;
      out_live  <= 1'b0;
      out_cnt   <= '0;
    end else if (cs_rise) begin
      phase    <= PH_IDLE;
      out_live <= 1'b0;
    end else begin
      if (sck_rise && shifting_in) begin
        in_sr  <= in_byte[6:0];
        bitcnt <= bitcnt + 1'b1;
        if (phase == PH_ADDR) addr_q <= addr_next;
        case (phase)
          PH_OPC: begin
            if (bitcnt == LAST_OPC) begin
              if (busy && in_byte != OPC_RDSR) begin
                phase  <= PH_IGNORE;
                opcode <= '0;
              end else begin
                opcode <= in_byte;
                case (in_byte)
                  OPC_READ, OPC_PROG: phase <= PH_ADDR;
                  OPC_RDSR: begin
                    phase      <= PH_STREAM;
                    src_status <= 1'b1;
                    out_cnt    <= '0;
                  end
                  default: phase <= PH_IGNORE;
                endcase
              end
            end
          end
          PH_ADDR: begin
            if (bitcnt == LAST_ADDR) begin
              if (opcode == OPC_READ) begin
                phase      <= PH_STREAM;
                src_status <= 1'b0;
                ptr        <= addr_next;
                out_cnt    <= '0;
              end else begin
                phase <= PH_DATA;
              end
            end
          end
          PH_DATA: begin
            if (bitcnt == LAST_DATA) begin
              prog_data <= in_byte;
              data_done <= 1'b1;
              phase     <= PH_IGNORE;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && phase == PH_STREAM) begin
        if (out_cnt == '0) begin
          out_sr   <= src_status ? {6'b0, wel, busy} : rd_byte;
          out_live <= 1'b1;
          if (!src_status) ptr <= ptr + 1'b1;
        end else begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
        out_cnt <= out_cnt + 1'b1;
      end
    end
  end

  assign rd_addr   = ptr;
  assign so_bit    = out_sr[7];
  assign so_oe     = out_live && (phase == PH_STREAM);
  assign wren_req  = cs_rise && (opcode == OPC_WREN);
  assign prog_req  = cs_rise && (opcode == OPC_PROG) && data_done;
  assign prog_addr = addr_q;

  // R4: the output is released right after deselect
  p_hiz_after_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  // R12: while Busy, only status data may be streamed
  p_status_only_when_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_STREAM) |-> src_status);

  // R3: the streaming pointer advances modulo the array size
  p_ptr_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && phase == PH_STREAM && !src_status && !cs_rise && !cs_fall
     && out_cnt == '0 && ptr == '1) |=> (ptr == '0));
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave #(
  parameter int AW          = 6,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  input  logic lock_upper,
  output logic spi_so,
  output logic spi_so_oe
);
  logic cs_lvl, sck_lvl, si_lvl;
  logic cs_prev, sck_prev;
  logic cs_rise, cs_fall, sck_rise, sck_fall;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(spi_cs_n), .level(cs_lvl));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .din(spi_sck), .level(sck_lvl));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst_n(rst_n), .din(spi_si), .level(si_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_lvl;
      sck_prev <= sck_lvl;
    end
  end

  assign cs_rise  = cs_lvl && !cs_prev;
  assign cs_fall  = !cs_lvl && cs_prev;
  assign sck_rise = sck_lvl && !sck_prev && !cs_lvl;
  assign sck_fall = !sck_lvl && sck_prev && !cs_lvl;

  logic          busy, wel, wren_req, prog_req, wr_en;
  logic [AW-1:0] rd_addr, prog_addr, wr_addr;
  logic [7:0]    rd_byte, prog_data, wr_data;

  flash_cmd_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_lvl),
    .busy(busy), .wel(wel), .rd_byte(rd_byte), .rd_addr(rd_addr),
    .so_bit(spi_so), .so_oe(spi_so_oe),
    .wren_req(wren_req), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data));

  flash_prog_ctrl #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .wren_req(wren_req), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .lock_upper(lock_upper),
    .busy(busy), .wel(wel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  flash_byte_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // R12: no array write can start inside a busy interval
  p_no_write_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> !wr_en);
endmodule

// File: tb/spi_flash_slave_tb.sv
module spi_flash_slave_tb;
  localparam int AW   = 6;
  localparam int PROG = 1500;
  localparam int H    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_n, sck, si, lock_upper;
  logic so, so_oe;
  int   n_tests = 0;
  int   n_fail  = 0;
  logic mode3   = 1'b0;
  logic oe_cmd_bad, oe_rd_low;
  logic [7:0] rbuf [16];

  spi_flash_slave #(.AW(AW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .lock_upper(lock_upper), .spi_so(so), .spi_so_oe(so_oe));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, input bit is_cmd, output logic r);
    sck = 1'b0;
    si  = b;
    repeat (H) @(negedge clk);
    r = so;
    if (is_cmd && so_oe) oe_cmd_bad = 1'b1;
    if (!is_cmd && !so_oe) oe_rd_low = 1'b1;
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] op, input bit with_addr, input logic [23:0] addr,
                     input int din_bits, input logic [7:0] din, input int nrd);
    logic r;
    oe_cmd_bad = 1'b0;
    oe_rd_low  = 1'b0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_io(op[i], 1'b1, r);
    if (with_addr) for (int i = 23; i >= 0; i--) bit_io(addr[i], 1'b1, r);
    for (int i = 0; i < din_bits; i++) bit_io(din[7-i], 1'b1, r);
    for (int k = 0; k < nrd; k++)
      for (int i = 7; i >= 0; i--) begin
        bit_io(1'b0, 1'b0, r);
        rbuf[k][i] = r;
      end
    if (!mode3) begin
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic wren();                       txn(8'h06, 0, 24'h0, 0, 8'h00, 0); endtask
  task automatic rdsr();                       txn(8'h05, 0, 24'h0, 0, 8'h00, 1); endtask
  task automatic rd(input logic [23:0] a, input int n);  txn(8'h03, 1, a, 0, 8'h00, n); endtask
  task automatic prog(input logic [23:0] a, input logic [7:0] d); txn(8'h02, 1, a, 8, d, 0); endtask
  task automatic wait_ready(); repeat (PROG + 100) @(negedge clk); endtask
  task automatic wprog(input logic [23:0] a, input logic [7:0] d);
    wren(); prog(a, d); wait_ready();
  endtask

  task automatic t_reset();
    check(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);
    rdsr();
    check(rbuf[0] == 8'h00, "R1 status after reset", rbuf[0], 8'h00);
    rd(24'h0, 4);
    for (int k = 0; k < 4; k++) check(rbuf[k] == 8'hFF, "R1 erased array", rbuf[k], 8'hFF);
    check(!oe_cmd_bad, "R4 oe low in opcode/address", oe_cmd_bad, 0);
    check(!oe_rd_low, "R4 oe high while streaming", oe_rd_low, 0);
    check(so_oe == 1'b0, "R4 oe low when deselected", so_oe, 0);
  endtask

  task automatic t_no_wel();
    prog(24'h5, 8'h0F);
    rdsr();
    check(rbuf[0] == 8'h00, "R8 status after unlatched program", rbuf[0], 8'h00);
    rd(24'h5, 1);
    check(rbuf[0] == 8'hFF, "R8 array untouched", rbuf[0], 8'hFF);
  endtask

  task automatic t_wren();
    wren();
    rdsr();
    check(rbuf[0] == 8'h02, "R6 latch set", rbuf[0], 8'h02);
  endtask

  task automatic t_program_busy();
    prog(24'h5, 8'hA5);
    rdsr();
    check(rbuf[0] == 8'h03, "R10 busy and latch during program", rbuf[0], 8'h03);
    rd(24'h5, 1);
    check(oe_rd_low == 1'b1, "R12 read ignored while busy", oe_rd_low, 1);
    wait_ready();
    rdsr();
    check(rbuf[0] == 8'h00, "R10 busy and latch cleared", rbuf[0], 8'h00);
    rd(24'h5, 1);
    check(rbuf[0] == 8'hA5, "R7 programmed byte", rbuf[0], 8'hA5);
    wprog(24'h5, 8'h5A);
    rd(24'h5, 1);
    check(rbuf[0] == 8'h00, "R7 program ANDs with old", rbuf[0], 8'h00);
  endtask

  task automatic t_lock();
    lock_upper = 1'b1;
    wren();
    prog(24'h28, 8'h3C);
    rdsr();
    check(rbuf[0] == 8'h02, "R9 locked program not started", rbuf[0], 8'h02);
    rd(24'h28, 1);
    check(rbuf[0] == 8'hFF, "R9 locked byte unchanged", rbuf[0], 8'hFF);
    lock_upper = 1'b0;
    prog(24'h28, 8'h3C);
    wait_ready();
    rd(24'h28, 1);
    check(rbuf[0] == 8'h3C, "R9 unlocked program lands", rbuf[0], 8'h3C);
  endtask

  task automatic t_abort();
    wren();
    txn(8'h02, 1, 24'h7, 5, 8'h00, 0);
    rdsr();
    check(rbuf[0] == 8'h02, "R11 short program discarded, latch kept", rbuf[0], 8'h02);
    rd(24'h7, 1);
    check(rbuf[0] == 8'hFF, "R11 byte unchanged", rbuf[0], 8'hFF);
  endtask

  task automatic t_stream();
    wprog(24'h8, 8'h12);
    wprog(24'h9, 8'h34);
    wprog(24'hA, 8'h56);
    rd(24'h8, 3);
    check(rbuf[0] == 8'h12, "R2 stream byte 0", rbuf[0], 8'h12);
    check(rbuf[1] == 8'h34, "R2 stream byte 1", rbuf[1], 8'h34);
    check(rbuf[2] == 8'h56, "R2 stream byte 2", rbuf[2], 8'h56);
    rd(24'h123408, 1);
    check(rbuf[0] == 8'h12, "R2 high address bits ignored", rbuf[0], 8'h12);
  endtask

  task automatic t_wrap();
    wprog(24'h3F, 8'h81);
    wprog(24'h0, 8'h7E);
    rd(24'h3E, 4);
    check(rbuf[0] == 8'hFF, "R3 byte before top", rbuf[0], 8'hFF);
    check(rbuf[1] == 8'h81, "R3 top byte", rbuf[1], 8'h81);
    check(rbuf[2] == 8'h7E, "R3 wrapped to zero", rbuf[2], 8'h7E);
    check(rbuf[3] == 8'hFF, "R3 continues after wrap", rbuf[3], 8'hFF);
  endtask

  task automatic t_mode3();
    mode3 = 1'b1;
    sck = 1'b1;
    repeat (2*H) @(negedge clk);
    rd(24'h8, 3);
    check(rbuf[0] == 8'h12, "R5 mode3 stream byte 0", rbuf[0], 8'h12);
    check(rbuf[2] == 8'h56, "R5 mode3 stream byte 2", rbuf[2], 8'h56);
    wren();
    rdsr();
    check(rbuf[0] == 8'h02, "R5 mode3 status", rbuf[0], 8'h02);
    prog(24'hB, 8'h99);
    wait_ready();
    rd(24'hB, 1);
    check(rbuf[0] == 8'h99, "R5 mode3 program", rbuf[0], 8'h99);
    check(!oe_cmd_bad, "R5 mode3 oe low in command", oe_cmd_bad, 0);
    mode3 = 1'b0;
    sck = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    wren();
    prog(24'h14, 8'h11);
    prog(24'h15, 8'h22);
    wren();
    wait_ready();
    rdsr();
    check(rbuf[0] == 8'h00, "R12 write-enable during busy dropped", rbuf[0], 8'h00);
    rd(24'h14, 2);
    check(rbuf[0] == 8'h11, "R12 first program kept", rbuf[0], 8'h11);
    check(rbuf[1] == 8'hFF, "R12 program during busy ignored", rbuf[1], 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; lock_upper = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_wel();
    t_wren();
    t_program_busy();
    t_lock();
    t_abort();
    t_stream();
    t_wrap();
    t_mode3();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule